// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter with Mixed Priority Classes

This block decides which of several DMA channels owns a shared bus. A channel competes only while it both requests and is enabled. Each channel belongs to one of two classes. The fixed class always beats the rotating class. Within the fixed class, the lowest channel index wins. Within the rotating class, the search starts one place past the last rotating winner.

Software sets a channel's class through two strobe ports: one sets the class to fixed, the other clears it back to rotating. The resulting class vector can be read back on its own output.

Once a channel wins, it keeps the bus for a whole burst. The burst ends when the channel has signalled a set number of completed transfers. That number comes from a 3-bit power-of-two code, or it is exactly one when the channel is in single-transfer mode. After the burst, arbitration runs again.

A burst can end early:
- when the channel's task completes;
- when the owning channel is paused or reset;
- when the owning channel is disabled.

The block has no data stream, so every pin is a plain level or strobe with no valid/ready handshake. The channel datapath is outside this block.

Top module: `dma_lane_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle.
- R2: A channel whose `ch_en` bit is low is never granted. If the owner's enable drops, its grant bit falls in that same cycle and ownership is released at the next clock edge.
- R3: A 1 on a bit of `prio_set` makes that channel fixed-class from the next cycle on. A 0 bit leaves the class unchanged. `prio_fixed` reads 1 for a fixed channel and 0 for a rotating one.
- R4: A 1 on a bit of `prio_clr` returns that channel to the rotating class from the next cycle on. When set and clear hit the same bit in the same cycle, clear wins.
- R5: When any competing channel is fixed-class, the lowest-indexed competing fixed channel wins.
- R6: When no competing channel is fixed, the winner is the first competing channel found by searching upward (wrapping around) from one past the last rotating-class winner. After reset, the last rotating winner is taken to be the highest channel.
- R7: A channel in burst mode keeps its grant for 2^(7-code) `xfer_done` pulses, with its burst code at bits [3c+2:3c] of `ch_code`. So code 000 gives 128 pulses, 011 gives 16 and 111 gives 1. The grant falls in the cycle after the last pulse.
- R8: With `ch_single` high, the grant ends after one `xfer_done` pulse, whatever the burst code.
- R9: A `task_end` pulse, or a `ch_halt` pulse on the owning channel, ends the grant at the next edge. A halt on a channel that does not own the bus leaves the current grant unchanged.
- R10: A grant appears one cycle after arbitration sees a competing channel while the bus is free. Between two grants there is at least one cycle with `grant` at zero.
- R11: After reset, `grant` is zero and every channel is in the rotating class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_req | input | 4 | Per-channel request |
| ch_en | input | 4 | Per-channel enable |
| ch_single | input | 4 | Per-channel single-transfer mode (1) or burst mode (0) |
| ch_code | input | 12 | Burst codes, 3 bits per channel, channel c at [3c+2:3c] |
| xfer_done | input | 1 | One transfer of the current owner finished |
| task_end | input | 1 | Owner's whole task finished; ends the grant early |
| ch_halt | input | 4 | Per-channel pause/reset strobe |
| prio_set | input | 4 | Write-one-to-set fixed class |
| prio_clr | input | 4 | Write-one-to-clear fixed class |
| prio_fixed | output | 4 | Class readback, 1 = fixed |
| grant | output | 4 | One-hot bus grant |

## Verification
The hardest state to reach from the ports is a particular rotation pointer combined with a particular class mix and request pattern. The pointer is never visible; it moves only when a rotating-class channel wins.

The bench sweeps every class vector against every non-empty request pattern. Each grant is completed with a single one-pulse burst, so each trial leaves the pointer in a new place. The bench carries its own copy of the pointer, derived from the grants it observes, and uses it to predict the next winner.

Burst lengths are covered by running all eight codes in both modes and counting done pulses up to the boundary.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_LOG2 = (1 << CODE_W) - 1;
  localparam int CNT_W    = MAX_LOG2 + 1;

  // Transfers per grant: 2^(MAX_LOG2-code), or one in single mode.
  function automatic logic [CNT_W-1:0] burst_len(input logic [CODE_W-1:0] code,
                                                  input logic single);
    if (single) return CNT_W'(1);
    return CNT_W'(1) << (MAX_LOG2 - int'(code));
  endfunction
endpackage

// File: rtl/arb_prio_reg.sv
module arb_prio_reg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] fixed_o
);
  logic [N-1:0] fixed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fixed_q <= '0;
    else        fixed_q <= (fixed_q | set_i) & ~clr_i;
  end

  assign fixed_o = fixed_q;

  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & ~clr_i)) |=> ((fixed_q & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
  a_r4_clr_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_i) |=> ((fixed_q & $past(clr_i)) == '0));
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     cand_i,
  input  logic [N-1:0]     fixed_i,
  input  logic [IDX_W-1:0] rr_last_i,
  output logic             win_vld_o,
  output logic [IDX_W-1:0] win_idx_o,
  output logic             win_fixed_o
);
  logic [N-1:0] fx_c, rr_c;
  logic         found;

  always_comb begin
    fx_c        = cand_i & fixed_i;
    rr_c        = cand_i & ~fixed_i;
    win_vld_o   = |cand_i;
    win_fixed_o = |fx_c;
    win_idx_o   = '0;
    found       = 1'b0;
    if (|fx_c) begin
      for (int i = N - 1; i >= 0; i--)
        if (fx_c[i]) win_idx_o = IDX_W'(i);
    end else begin
      for (int k = 1; k <= N; k++) begin
        if (!found && rr_c[(int'(rr_last_i) + k) % N]) begin
          win_idx_o = IDX_W'((int'(rr_last_i) + k) % N);
          found     = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/arb_burst_cnt.sv
module arb_burst_cnt
  import arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= len_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));

  a_r7_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (len_i != '0));
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> (cnt_q != '0));
endmodule

// File: rtl/dma_lane_arbiter.sv
module dma_lane_arbiter
  import arb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        ch_req,
  input  logic [N-1:0]        ch_en,
  input  logic [N-1:0]        ch_single,
  input  logic [N*CODE_W-1:0] ch_code,
  input  logic                xfer_done,
  input  logic                task_end,
  input  logic [N-1:0]        ch_halt,
  input  logic [N-1:0]        prio_set,
  input  logic [N-1:0]        prio_clr,
  output logic [N-1:0]        prio_fixed,
  output logic [N-1:0]        grant
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]     fixed, cand;
  logic             own_vld, win_vld, win_fixed, take, release_c, last;
  logic [IDX_W-1:0] own_idx, win_idx, rr_last;
  logic [CODE_W-1:0] sel_code;

  arb_prio_reg #(.N(N)) u_prio (
    .clk(clk), .rst_n(rst_n), .set_i(prio_set), .clr_i(prio_clr), .fixed_o(fixed)
  );

  assign cand = ch_req & ch_en & ~ch_halt;

  arb_pick #(.N(N), .IDX_W(IDX_W)) u_pick (
    .cand_i(cand), .fixed_i(fixed), .rr_last_i(rr_last),
    .win_vld_o(win_vld), .win_idx_o(win_idx), .win_fixed_o(win_fixed)
  );

  assign sel_code  = ch_code[int'(win_idx)*CODE_W +: CODE_W];
  assign take      = !own_vld && win_vld;
  assign release_c = own_vld && (task_end || ch_halt[own_idx] || !ch_en[own_idx] ||
                                 (xfer_done && last));

  arb_burst_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(take),
    .len_i(burst_len(sel_code, ch_single[win_idx])),
    .dec_i(own_vld && xfer_done), .last_o(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_idx <= '0;
      rr_last <= IDX_W'(N - 1);
    end else if (take) begin
      own_vld <= 1'b1;
      own_idx <= win_idx;
      if (!win_fixed) rr_last <= win_idx;
    end else if (release_c) begin
      own_vld <= 1'b0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    assign grant[g] = own_vld && (own_idx == IDX_W'(g)) && ch_en[g];
  end

  assign prio_fixed = fixed;

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  a_r2_win_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld |-> ch_en[win_idx]);
  a_r5_fixed_first: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vld && |(cand & fixed)) |-> fixed[win_idx]);
  a_r9_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
    (own_vld && ch_halt[own_idx]) |=> !own_vld);
  a_r10_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(grant) != '0) && (grant != '0)) |-> (grant == $past(grant)));
endmodule

// File: tb/sim_dma_lane_arbiter.sv
`timescale 1ns/1ps
module sim_dma_lane_arbiter;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [3:0]  ch_req = '0, ch_en = '0, ch_single = '0, ch_halt = '0;
  logic [3:0]  prio_set = '0, prio_clr = '0;
  logic [11:0] ch_code = '0;
  logic        xfer_done = 1'b0, task_end = 1'b0;
  logic [3:0]  prio_fixed, grant;
  int          n_chk = 0, n_bad = 0, rr_m = 3;
  bit          done_flag = 0;

  always #4 clk = ~clk;

  dma_lane_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_en(ch_en), .ch_single(ch_single),
    .ch_code(ch_code), .xfer_done(xfer_done), .task_end(task_end), .ch_halt(ch_halt),
    .prio_set(prio_set), .prio_clr(prio_clr), .prio_fixed(prio_fixed), .grant(grant)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  function automatic int exp_win(int pat, int fx, int rrl);
    if ((pat & fx) != 0) begin
      for (int i = 0; i < 4; i++) if (((pat & fx) >> i) & 1) return i;
    end
    for (int k = 1; k <= 4; k++)
      if (((pat & ~fx) >> ((rrl + k) % 4)) & 1) return (rrl + k) % 4;
    return -1;
  endfunction

  task automatic load_fixed(input logic [3:0] p);
    prio_clr = 4'hF; step();
    prio_clr = '0; prio_set = p; step();
    prio_set = '0;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    step(); step();
    chk("R11 reset grant", grant, 0);
    chk("R11 reset class", prio_fixed, 0);
    rst_n = 1'b1; step();

    // R3 / R4 class register sweep
    for (int p = 0; p < 16; p++) begin
      load_fixed(4'(p)); step();
      chk("R3 set readback", prio_fixed, p);
      prio_set = '0; step();
      chk("R3 zero no effect", prio_fixed, p);
      prio_set = 4'hF; prio_clr = 4'(p); step();
      chk("R4 clear wins", prio_fixed, 4'hF & ~p);
      prio_set = '0; prio_clr = 4'(~p); step();
      prio_clr = '0;
      chk("R4 clear returns", prio_fixed, 0);
    end

    // R5 / R6 / R7 arbitration sweep, one-transfer bursts
    ch_en = 4'hF; ch_code = 12'hFFF;
    for (int fx = 0; fx < 16; fx++) begin
      for (int pat = 1; pat < 16; pat++) begin
        int w;
        load_fixed(4'(fx));
        w = exp_win(pat, fx, rr_m);
        ch_req = 4'(pat); step();
        chk((pat & fx) != 0 ? "R5 fixed winner" : "R6 rotate winner", grant, 1 << w);
        if (((fx >> w) & 1) == 0) rr_m = w;
        ch_req = '0; xfer_done = 1'b1; step();
        xfer_done = 1'b0;
        chk("R7 code 111 release", grant, 0);
      end
    end
    load_fixed(4'h0);

    // R7 / R8 burst lengths on channel 2
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 8; c++) begin
        int len;
        len = (s != 0) ? 1 : (1 << (7 - c));
        ch_single = (s != 0) ? 4'h4 : 4'h0;
        ch_code = 12'(c) << 6;
        ch_req = 4'h4; step();
        chk(s != 0 ? "R8 single grant" : "R7 burst grant", grant, 4'h4);
        rr_m = 2;
        ch_req = '0;
        for (int n = 1; n < len; n++) begin
          xfer_done = 1'b1; step();
          if (n == len - 1) chk("R7 held before last", grant, 4'h4);
        end
        xfer_done = 1'b1; step();
        xfer_done = 1'b0;
        chk(s != 0 ? "R8 single release" : "R7 burst release", grant, 0);
      end
    end
    ch_single = '0;

    // R2 enable gating
    ch_code = '0; ch_en = '0; ch_req = 4'hF;
    step(); step();
    chk("R2 disabled never granted", grant, 0);
    ch_en = 4'h2; step();
    chk("R2 enabled channel wins", grant, 4'h2);
    rr_m = 1;
    ch_en = 4'h0; #1;
    chk("R2 enable drop same cycle", grant, 0);
    step(); ch_req = '0; ch_en = 4'hF; #1;
    chk("R2 owner released", grant, 0);
    step();

    // R9 early release
    ch_req = 4'h1; step();
    chk("R9 grant before end", grant, 4'h1);
    rr_m = 0;
    ch_req = '0; ch_halt = 4'h2; step();
    ch_halt = '0;
    chk("R9 foreign halt ignored", grant, 4'h1);
    task_end = 1'b1; step();
    task_end = 1'b0;
    chk("R9 task end release", grant, 0);
    ch_req = 4'h8; step();
    chk("R9 grant before halt", grant, 4'h8);
    rr_m = 3;
    ch_req = '0; ch_halt = 4'h8; step();
    ch_halt = '0;
    chk("R9 halt release", grant, 0);

    // R10 / R6 continuous requests from two channels
    ch_code = 12'hFFF; ch_req = 4'h3; step();
    chk("R10 first grant", grant, 4'h1);
    xfer_done = 1'b1; step();
    xfer_done = 1'b0;
    chk("R10 idle gap", grant, 0);
    step();
    chk("R6 rotation to next", grant, 4'h2);
    xfer_done = 1'b1; step();
    xfer_done = 1'b0; ch_req = '0;
    chk("R10 second gap", grant, 0);
    step();
    chk("R10 no request no grant", grant, 0);

    finish_run();
  end
endmodule